// File: doc/BRIEF.md
# SPI Serial EEPROM Slave

This block models the slave side of a small byte-wide serial EEPROM behind a four-wire SPI link in mode 0. The host drives chip select (active low), a serial clock and serial data in. The block returns serial data out together with an output enable. When the enable is low, the pad driver sits at high impedance. All four link pins are oversampled in the system clock domain. Edges are found after a synchronizer, so the SPI clock must run well below the system clock.

Every frame opens with an 8-bit opcode. Four opcodes are decoded: read, status read, write enable and write. A read takes one address byte and then streams bytes from an internal register array for as long as chip select stays low. The address wraps from the top of the array back to zero. Writes have to be armed by a write-enable latch, and that latch is only set once a complete write-enable frame has ended. Write data collects in a small page buffer. It is committed when chip select rises, but only if the frame ends on a byte boundary. A commit starts a busy timer, and the status byte can still be read while that timer runs.

Top module: `spi_ee_slave`

## Requirements
- R1: After reset, so_oe_o is low, the status byte reads 8'h00 and every memory byte reads 8'h00.
- R2: Opcode 8'h03 followed by an address byte returns the byte at that address, MSB first. Each bit changes after a falling SCK edge and is valid at the next rising edge.
- R3: During a read, the address advances by one after each byte that is shifted out, and it wraps from 8'hFF to 8'h00.
- R4: Opcode 8'h05 returns the status byte {6'b0, write_enable (bit 1), busy (bit 0)}, MSB first, and keeps repeating it while chip select stays low.
- R5: so_oe_o is low while chip select is high and during the opcode and address phases. It is high only while read or status data is being shifted out.
- R6: Opcode 8'h06 sets the write-enable latch only when chip select rises right after exactly eight bits. Any further SCK edge in that frame cancels it.
- R7: A write frame (opcode 8'h02) leaves memory and status unchanged if the write-enable latch was clear when the opcode completed. This includes a write opcode sent in the same frame as a write-enable opcode.
- R8: A write stores its data bytes in a 4-byte page picked by address bits [7:2]. The low two bits wrap within that page, and later bytes overwrite earlier ones. Nothing is stored, and the latch stays set, if the frame ends mid-byte or carries no data byte.
- R9: A committed write sets busy for BUSY_CYCLES system clocks. The write-enable latch clears when busy ends. Status stays readable while busy is set.
- R10: While busy is set, every opcode except 8'h05 is ignored.
- R11: An unknown opcode is ignored, and so_oe_o stays low until chip select rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, used for oversampling and the busy timer |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_ni | input | 1 | Chip select, active low |
| sck_i | input | 1 | SPI serial clock, idles low (mode 0) |
| si_i | input | 1 | Serial data from the host |
| so_o | output | 1 | Serial data to the host, meaningful only while so_oe_o is high |
| so_oe_o | output | 1 | Output enable for the serial data pad; low means high impedance |

## Verification
The assertions check several rules on every cycle:
- the output enable drops once chip select is high, and is only ever high in a read-data or status state;
- the write-enable latch rises only on a chip-select rising edge, and falls only when the busy timer expires;
- busy never starts unless the latch was set;
- the memory array never changes outside a commit.

Other behaviours need a full frame to show up, so only the bench scenarios can demonstrate them. These are: the exact byte values and their bit order, the address wrap, page wrap inside a write, cancelling a write enable with an extra clock, rejecting a partial-byte write, and ignoring opcodes while busy. The bench covers them by filling and reading back the whole array against an arithmetic pattern.

// File: rtl/spi_ee_pkg.sv
package spi_ee_pkg;
  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_RDSR  = 8'h05;
  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_WRITE = 8'h02;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_OPC,
    ST_RADDR,
    ST_RDATA,
    ST_RSTAT,
    ST_WEN,
    ST_WADDR,
    ST_WDATA,
    ST_SKIP
  } ee_state_e;
endpackage

// File: rtl/spi_ee_sync.sv
module spi_ee_sync #(
  parameter int          N       = 3,
  parameter int          STAGES  = 2,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] q_o
);
  for (genvar b = 0; b < N; b++) begin : g_bit
    logic [STAGES-1:0] ff_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ff_q <= {STAGES{RST_VAL[b]}};
      else         ff_q <= {ff_q[STAGES-2:0], d_i[b]};
    end
    assign q_o[b] = ff_q[STAGES-1];
  end
endmodule

// File: rtl/spi_ee_busy.sv
module spi_ee_busy #(
  parameter int CYCLES = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o,
  output logic done_o
);
  localparam int CNT_W = $clog2(CYCLES + 1);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (start_i)      cnt_q <= CNT_W'(CYCLES);
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);
  assign done_o = (cnt_q == CNT_W'(1)) && !start_i;

  assert_busy_ends_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o);
endmodule

// File: rtl/spi_ee_mem.sv
module spi_ee_mem #(
  parameter int ADDR_W = 8,
  parameter int PAGE_W = 2
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [ADDR_W-1:0]             rd_addr_i,
  output logic [7:0]                    rd_data_o,
  input  logic                          wr_en_i,
  input  logic [ADDR_W-PAGE_W-1:0]      wr_page_i,
  input  logic [(1<<PAGE_W)-1:0][7:0]   wr_data_i,
  input  logic [(1<<PAGE_W)-1:0]        wr_mask_i
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int PAGE  = 1 << PAGE_W;

  logic [DEPTH-1:0][7:0] mem_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_q <= '0;
    end else if (wr_en_i) begin
      for (int i = 0; i < PAGE; i++) begin
        if (wr_mask_i[i]) mem_q[{wr_page_i, PAGE_W'(i)}] <= wr_data_i[i];
      end
    end
  end

  assign rd_data_o = mem_q[rd_addr_i];

  assert_mem_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(mem_q));
endmodule

// File: rtl/spi_ee_slave.sv
module spi_ee_slave
  import spi_ee_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int PAGE_W      = 2,
  parameter int BUSY_CYCLES = 500,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_ni,
  input  logic sck_i,
  input  logic si_i,
  output logic so_o,
  output logic so_oe_o
);
  localparam int PAGE = 1 << PAGE_W;
  localparam int PG_W = ADDR_W - PAGE_W;

  logic cs_s, sck_s, si_s, cs_d, sck_d;
  logic cs_fall, cs_rise, sck_rise, sck_fall;

  spi_ee_sync #(.N(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({cs_ni, sck_i, si_i}),
    .q_o   ({cs_s, sck_s, si_s})
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_d  <= 1'b1;
      sck_d <= 1'b0;
    end else begin
      cs_d  <= cs_s;
      sck_d <= sck_s;
    end
  end

  assign cs_fall  = cs_d & ~cs_s;
  assign cs_rise  = ~cs_d & cs_s;
  assign sck_rise = ~sck_d & sck_s & ~cs_s;
  assign sck_fall = sck_d & ~sck_s & ~cs_s;

  ee_state_e                 st_q, op_st;
  logic [2:0]                bit_cnt_q, out_idx_q;
  logic [7:0]                sr_q, sr_next, out_byte, rd_data, status;
  logic [ADDR_W-1:0]         addr_q;
  logic                      wel_q, oe_q, so_q;
  logic [PG_W-1:0]           pg_base_q;
  logic [PAGE_W-1:0]         pg_slot_q;
  logic [PAGE-1:0][7:0]      pg_buf_q;
  logic [PAGE-1:0]           pg_mask_q;
  logic                      busy, busy_done, commit, byte_done;

  assign sr_next   = {sr_q[6:0], si_s};
  assign byte_done = (bit_cnt_q == 3'd7);
  assign status    = {6'b0, wel_q, busy};
  assign out_byte  = (st_q == ST_RDATA) ? rd_data : status;

  // Only status reads are decoded while the write cycle runs.
  always_comb begin
    if (busy) begin
      op_st = (sr_next == OP_RDSR) ? ST_RSTAT : ST_SKIP;
    end else begin
      case (sr_next)
        OP_READ:  op_st = ST_RADDR;
        OP_RDSR:  op_st = ST_RSTAT;
        OP_WREN:  op_st = ST_WEN;
        OP_WRITE: op_st = wel_q ? ST_WADDR : ST_SKIP;
        default:  op_st = ST_SKIP;
      endcase
    end
  end

  assign commit = cs_rise && (st_q == ST_WDATA) && (bit_cnt_q == 3'd0)
                  && (|pg_mask_q) && wel_q && !busy;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      bit_cnt_q <= '0;
      out_idx_q <= '0;
      sr_q      <= '0;
      addr_q    <= '0;
      wel_q     <= 1'b0;
      oe_q      <= 1'b0;
      so_q      <= 1'b0;
      pg_base_q <= '0;
      pg_slot_q <= '0;
      pg_buf_q  <= '0;
      pg_mask_q <= '0;
    end else begin
      if (busy_done) wel_q <= 1'b0;
      if (cs_fall) begin
        st_q      <= ST_OPC;
        bit_cnt_q <= '0;
        out_idx_q <= '0;
        oe_q      <= 1'b0;
        pg_mask_q <= '0;
      end else if (cs_rise) begin
        st_q <= ST_IDLE;
        oe_q <= 1'b0;
        if (st_q == ST_WEN) wel_q <= 1'b1;
      end else if (sck_rise) begin
        sr_q      <= sr_next;
        bit_cnt_q <= bit_cnt_q + 3'd1;
        case (st_q)
          ST_WEN:   st_q <= ST_SKIP;
          ST_OPC:   if (byte_done) st_q <= op_st;
          ST_RADDR: if (byte_done) begin
            addr_q <= sr_next[ADDR_W-1:0];
            st_q   <= ST_RDATA;
          end
          ST_WADDR: if (byte_done) begin
            pg_base_q <= sr_next[ADDR_W-1:PAGE_W];
            pg_slot_q <= sr_next[PAGE_W-1:0];
            st_q      <= ST_WDATA;
          end
          ST_WDATA: if (byte_done) begin
            pg_buf_q[pg_slot_q]  <= sr_next;
            pg_mask_q[pg_slot_q] <= 1'b1;
            pg_slot_q            <= pg_slot_q + 1'b1;
          end
          default: ;
        endcase
      end else if (sck_fall && (st_q == ST_RDATA || st_q == ST_RSTAT)) begin
        so_q      <= out_byte[~out_idx_q];
        oe_q      <= 1'b1;
        out_idx_q <= out_idx_q + 3'd1;
        if (out_idx_q == 3'd7 && st_q == ST_RDATA) addr_q <= addr_q + 1'b1;
      end
    end
  end

  spi_ee_mem #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_mem (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rd_addr_i(addr_q),
    .rd_data_o(rd_data),
    .wr_en_i  (commit),
    .wr_page_i(pg_base_q),
    .wr_data_i(pg_buf_q),
    .wr_mask_i(pg_mask_q)
  );

  spi_ee_busy #(.CYCLES(BUSY_CYCLES)) u_busy (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(commit),
    .busy_o (busy),
    .done_o (busy_done)
  );

  assign so_o    = so_q;
  assign so_oe_o = oe_q;

  assert_oe_off_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_s |=> !so_oe_o);
  assert_oe_state_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    so_oe_o |-> (st_q == ST_RDATA || st_q == ST_RSTAT));
  assert_wel_set_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wel_q) |-> $past(cs_rise));
  assert_busy_needs_wel_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy) |-> $past(wel_q));
  assert_wel_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(wel_q) |-> $past(busy_done));
endmodule

// File: tb/spi_ee_slave_tb_top.sv
`timescale 1ns/1ps
module spi_ee_slave_tb_top;
  localparam int HALF = 5;
  localparam int BUSY = 500;

  logic clk = 1'b0, rst_ni = 1'b0, cs_n = 1'b1, sck = 1'b0, si = 1'b0;
  logic so, so_oe;
  int   checks = 0, errors = 0;
  bit   finished = 1'b0;
  logic [7:0] exp_mem [256];
  logic [7:0] wbuf [8];

  always #2.5 clk = ~clk;

  spi_ee_slave #(.BUSY_CYCLES(BUSY)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .cs_ni(cs_n), .sck_i(sck), .si_i(si),
    .so_o(so), .so_oe_o(so_oe)
  );

  task automatic chk_eq(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wclk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cs_lo();
    cs_n = 1'b0;
    wclk(HALF);
  endtask

  task automatic cs_hi();
    sck = 1'b0;
    wclk(2);
    cs_n = 1'b1;
    wclk(12);
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx, output int oe_n);
    oe_n = 0;
    for (int i = 7; i >= 0; i--) begin
      si = tx[i];
      wclk(HALF);
      rx[i] = so;
      if (so_oe) oe_n++;
      sck = 1'b1;
      wclk(HALF);
      sck = 1'b0;
    end
  endtask

  task automatic rdsr(output logic [7:0] st);
    logic [7:0] rx;
    int oe_n;
    cs_lo();
    xfer(8'h05, rx, oe_n);
    chk_eq("R5", "oe during status opcode", oe_n, 0);
    xfer(8'h00, st, oe_n);
    chk_eq("R4", "oe during status byte", oe_n, 8);
    cs_hi();
  endtask

  task automatic read_chk(string req, logic [7:0] addr, int n);
    logic [7:0] rx;
    int oe_n;
    cs_lo();
    xfer(8'h03, rx, oe_n);
    chk_eq("R5", "oe during read opcode", oe_n, 0);
    xfer(addr, rx, oe_n);
    chk_eq("R5", "oe during address", oe_n, 0);
    for (int k = 0; k < n; k++) begin
      xfer(8'h00, rx, oe_n);
      chk_eq(req, $sformatf("read byte at %0h", 8'(addr + k)), rx, exp_mem[8'(addr + k)]);
      if (k == 0) chk_eq("R2", "oe during data", oe_n, 8);
    end
    cs_hi();
  endtask

  task automatic write_frame(logic [7:0] addr, int n, int extra);
    logic [7:0] rx;
    int oe_n;
    cs_lo();
    xfer(8'h02, rx, oe_n);
    xfer(addr, rx, oe_n);
    for (int k = 0; k < n; k++) xfer(wbuf[k], rx, oe_n);
    for (int e = 0; e < extra; e++) begin
      wclk(HALF); sck = 1'b1; wclk(HALF); sck = 1'b0;
    end
    cs_hi();
  endtask

  task automatic model_write(logic [7:0] addr, int n);
    for (int k = 0; k < n; k++)
      exp_mem[(addr & 8'hFC) | ((addr + k) & 8'h03)] = wbuf[k];
  endtask

  task automatic wren();
    logic [7:0] rx;
    int oe_n;
    cs_lo();
    xfer(8'h06, rx, oe_n);
    cs_hi();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] st, rx;
    int oe_n;
    for (int a = 0; a < 256; a++) exp_mem[a] = 8'h00;
    wclk(5);
    rst_ni = 1'b1;
    wclk(5);

    // R1 reset state
    chk_eq("R1", "oe after reset", so_oe, 0);
    rdsr(st);
    chk_eq("R1", "status after reset", st, 8'h00);
    read_chk("R1", 8'h00, 4);

    // R7 write without enable
    wbuf[0] = 8'hAA;
    write_frame(8'h10, 1, 0);
    rdsr(st);
    chk_eq("R7", "status after unarmed write", st, 8'h00);
    read_chk("R7", 8'h10, 1);

    // R6/R7 enable and write in the same frame
    cs_lo();
    xfer(8'h06, rx, oe_n);
    xfer(8'h02, rx, oe_n);
    xfer(8'h10, rx, oe_n);
    xfer(8'h55, rx, oe_n);
    cs_hi();
    rdsr(st);
    chk_eq("R6", "latch after extended enable frame", st, 8'h00);
    read_chk("R7", 8'h10, 1);

    // R11 unknown opcode
    cs_lo();
    xfer(8'hA5, rx, oe_n);
    xfer(8'h00, rx, oe_n);
    chk_eq("R11", "oe after unknown opcode", oe_n, 0);
    xfer(8'h00, rx, oe_n);
    chk_eq("R11", "oe after unknown opcode 2", oe_n, 0);
    cs_hi();
    rdsr(st);
    chk_eq("R11", "status after unknown opcode", st, 8'h00);

    // R6 clean enable, R4 repeating status
    wren();
    cs_lo();
    xfer(8'h05, rx, oe_n);
    xfer(8'h00, st, oe_n);
    chk_eq("R4", "status first byte", st, 8'h02);
    xfer(8'h00, st, oe_n);
    chk_eq("R4", "status repeated byte", st, 8'h02);
    cs_hi();

    // R8 partial byte and empty write frames keep memory and latch
    wbuf[0] = 8'h77;
    write_frame(8'h20, 1, 3);
    rdsr(st);
    chk_eq("R8", "status after partial write", st, 8'h02);
    write_frame(8'h20, 0, 0);
    rdsr(st);
    chk_eq("R8", "status after empty write", st, 8'h02);
    read_chk("R8", 8'h20, 1);

    // R8/R9/R10 fill the array page by page
    for (int p = 0; p < 64; p++) begin
      logic [7:0] base;
      base = 8'(p * 4);
      for (int k = 0; k < 4; k++) wbuf[k] = 8'((p * 4 + k) * 37 + 11);
      wren();
      write_frame(base, 4, 0);
      if (p == 0) begin
        cs_lo();
        xfer(8'h03, rx, oe_n);
        xfer(8'h00, rx, oe_n);
        xfer(8'h00, rx, oe_n);
        chk_eq("R10", "oe for read while busy", oe_n, 0);
        cs_hi();
      end
      rdsr(st);
      chk_eq("R9", "status while busy", st, 8'h03);
      model_write(base, 4);
      wclk(BUSY);
      rdsr(st);
      chk_eq("R9", "status after busy", st, 8'h00);
    end

    // R2/R3 full sequential read with wrap
    read_chk("R3", 8'h00, 260);
    read_chk("R3", 8'hFE, 4);

    // R8 page wrap inside a single write
    for (int k = 0; k < 6; k++) wbuf[k] = 8'hC0 + 8'(k);
    wren();
    write_frame(8'h41, 6, 0);
    model_write(8'h41, 6);
    wclk(BUSY + 20);
    read_chk("R8", 8'h3F, 6);
    rdsr(st);
    chk_eq("R9", "status after page write", st, 8'h00);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule